// File: doc/BRIEF.md
# Video Control Signal Glitch Filter

This block conditions the three slow video control lines of a parallel pixel bus: data enable, horizontal sync and vertical sync. It runs on the pixel clock. When the filter mode is selected, any level that does not stay put for a minimum number of clocks is discarded. Levels that do stay put appear at the output after a fixed delay. In every other mode the lines are passed through a single register stage.

In parallel with the filter, a monitor watches each raw control line against a transition budget over a sliding window of clocks. The monitor runs in every mode. Data enable and horizontal sync may toggle at most twice in any window. Vertical sync may toggle at most once in a window, which also sets a floor on its pulse width. Each channel has a sticky violation flag. Only reset clears it.

Top module: `vctl_glitch_filter`

## Requirements
- R1: During and directly after reset, `ctl_filt` is 3'b000 and `budget_viol` is 3'b000. The filter history also starts low.
- R2: Filtering is active only when `mode_code` is 2'b01. For codes 2'b00, 2'b10 and 2'b11, `ctl_filt` equals the value of `ctl_raw` sampled at the previous rising clock edge.
- R3: In filter mode, a new level that is sampled on 3 consecutive edges appears on `ctl_filt` at the third edge after the edge that first sampled it. Latency is fixed at 3 clocks, and a 3-cycle pulse passes through.
- R4: In filter mode, a high-going pulse that is sampled on only 1 or 2 edges never reaches `ctl_filt`.
- R5: In filter mode, a low-going glitch that is sampled on only 1 or 2 edges never reaches `ctl_filt`.
- R6: The channels are independent: bit 0 is data enable, bit 1 is horizontal sync and bit 2 is vertical sync. A glitch on one bit does not alter the filtering of the others.
- R7: For bits 0 and 1, in any mode, `budget_viol` sets when a third raw transition comes less than 130 clocks after the first of the three. A spacing of exactly 130 clocks does not set it, and neither do only two transitions, however close.
- R8: For bit 2, `budget_viol` sets when two raw transitions come less than 130 clocks apart, that is, a pulse shorter than 130 clocks. A spacing of exactly 130 clocks does not set it.
- R9: Once set, a `budget_viol` bit stays set, whatever the inputs or mode, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_code | input | 2 | 2'b01 selects filtering; every other code bypasses the filter |
| ctl_raw | input | 3 | Raw controls: bit 0 data enable, bit 1 hsync, bit 2 vsync |
| ctl_filt | output | 3 | Filtered or registered controls, same bit order |
| budget_viol | output | 3 | Sticky per-channel transition budget violation flags |

## Verification
The assertions assume that `ctl_raw` and `mode_code` are synchronous to `clk` and settle well before each rising edge. They also assume that `rst_n` is held low for at least one edge before any check counts. The bench meets this by changing every input only just after a falling edge. It starts every scenario with a fresh reset, so the sticky flags and the history of one case do not leak into the next. The filtered-path assertion looks only two edges back. It is therefore valid for any legal minimum width, while the bench pins down the exact three-clock latency.

// File: rtl/vcf_pkg.sv
// Shared definitions for the video control glitch filter.
// Assumes three control channels in a fixed bit order.
package vcf_pkg;
    typedef enum logic [1:0] {
        VCF_MODE_PASS = 2'b00,
        VCF_MODE_FILT = 2'b01,
        VCF_MODE_LEGA = 2'b10,
        VCF_MODE_LEGB = 2'b11
    } vcf_mode_e;

    localparam int unsigned VCF_NCH   = 3;
    localparam int unsigned VCF_CH_VS = 2;
endpackage

// File: rtl/vcf_deglitch.sv
// One-channel deglitcher. With en high, the output takes a new level only
// once MIN_W consecutive samples agree on it, which gives MIN_W clocks of
// latency. With en low, the output is a single register of the input.
// Assumes MIN_W >= 2 and an input synchronous to clk.
module vcf_deglitch #(
    parameter int unsigned MIN_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic [MIN_W-1:0] hist;
    logic             agree;
    logic             out_q;

    // Purpose: history is unanimous (all ones or all zeros).
    always_comb begin
        agree = (&hist) | ~(|hist);
    end

    // Purpose: shift the sample history and update the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist  <= '0;
            out_q <= 1'b0;
        end else begin
            hist <= {hist[MIN_W-2:0], din};
            if (en) begin
                if (agree) begin
                    out_q <= hist[0];
                end
            end else begin
                out_q <= din;
            end
        end
    end

    assign dout = out_q;

    // R2: in bypass, the output is the input one edge later.
    a_r2_bypass_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (dout == $past(din)));

    // R3: a filtered output change carries a level seen on the input earlier.
    a_r3_change_from_held_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (dout != $past(dout))) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/vcf_budget_mon.sv
// One-channel transition budget monitor. It keeps saturating ages of the
// last BUDGET transitions. A new transition while the oldest tracked age is
// below WIN sets a sticky flag, so BUDGET+1 transitions in fewer than WIN
// clocks are flagged. Assumes BUDGET >= 1 and a synchronous input.
module vcf_budget_mon #(
    parameter int unsigned WIN    = 130,
    parameter int unsigned BUDGET = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic viol
);
    localparam int unsigned AW = $clog2(WIN + 1);
    localparam logic [AW-1:0] WIN_C = AW'(WIN);

    logic          prev_q;
    logic          toggled;
    logic [AW-1:0] age [BUDGET];
    logic          viol_q;

    // Purpose: detect a raw transition against the last sample.
    always_comb begin
        toggled = (din != prev_q);
    end

    // Purpose: age the tracked transitions and latch the violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            viol_q <= 1'b0;
            for (int i = 0; i < BUDGET; i++) begin
                age[i] <= WIN_C;
            end
        end else begin
            prev_q <= din;
            if (toggled && (age[BUDGET-1] < WIN_C)) begin
                viol_q <= 1'b1;
            end
            if (toggled) begin
                age[0] <= AW'(1);
                for (int i = 1; i < BUDGET; i++) begin
                    age[i] <= (age[i-1] == WIN_C) ? WIN_C : age[i-1] + AW'(1);
                end
            end else begin
                for (int i = 0; i < BUDGET; i++) begin
                    age[i] <= (age[i] == WIN_C) ? WIN_C : age[i] + AW'(1);
                end
            end
        end
    end

    assign viol = viol_q;

    // R9: the flag never drops while out of reset.
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);

    // R7: a transition with the oldest tracked age at the window never flags.
    a_r7_spaced_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (toggled && (age[BUDGET-1] == WIN_C) && !viol) |=> !viol);
endmodule

// File: rtl/vctl_glitch_filter.sv
// Top of the video control glitch filter: three independent channels, each
// with a deglitcher and a transition budget monitor. Only mode 2'b01
// enables filtering. The monitors watch the raw inputs in every mode.
// Assumes all inputs are synchronous to clk.
module vctl_glitch_filter
    import vcf_pkg::*;
#(
    parameter int unsigned WIN          = 130,
    parameter int unsigned MIN_W        = 3,
    parameter int unsigned DE_HS_BUDGET = 2,
    parameter int unsigned VS_BUDGET    = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_code,
    input  logic [VCF_NCH-1:0]   ctl_raw,
    output logic [VCF_NCH-1:0]   ctl_filt,
    output logic [VCF_NCH-1:0]   budget_viol
);
    logic filt_en;

    // Purpose: decode the mode code into the filter enable.
    always_comb begin
        filt_en = (mode_code == VCF_MODE_FILT);
    end

    for (genvar g = 0; g < VCF_NCH; g++) begin : g_ch
        localparam int unsigned BUD = (g == VCF_CH_VS) ? VS_BUDGET : DE_HS_BUDGET;

        vcf_deglitch #(.MIN_W(MIN_W)) i_dg (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (filt_en),
            .din  (ctl_raw[g]),
            .dout (ctl_filt[g])
        );

        vcf_budget_mon #(.WIN(WIN), .BUDGET(BUD)) i_mon (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (ctl_raw[g]),
            .viol (budget_viol[g])
        );
    end

    // R1: outputs are clear in the cycle after a reset edge.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> ((ctl_filt == '0) && (budget_viol == '0)));
endmodule

// File: tb/test_vctl_glitch_filter.sv
module test_vctl_glitch_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_code = 2'b00;
    logic [2:0] ctl_raw = 3'b000;
    logic [2:0] ctl_filt;
    logic [2:0] budget_viol;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    vctl_glitch_filter i_vctl_glitch_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_code  (mode_code),
        .ctl_raw    (ctl_raw),
        .ctl_filt   (ctl_filt),
        .budget_viol(budget_viol)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        ctl_raw = 3'b000;
        mode_code = m;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(2'b01);
        chk("R1 filt after reset", ctl_filt, 3'b000);
        chk("R1 viol after reset", budget_viol, 3'b000);
    endtask

    task automatic t_bypass(input logic [1:0] m);
        do_reset(m);
        ctl_raw = 3'b101;
        tick();
        chk("R2 bypass one stage", ctl_filt, 3'b101);
        ctl_raw = 3'b010;
        tick();
        chk("R2 bypass follow", ctl_filt, 3'b010);
    endtask

    task automatic t_latency();
        do_reset(2'b01);
        ctl_raw = 3'b001;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 hold before latency", ctl_filt, 3'b000);
        end
        tick();
        chk("R3 rise at latency 3", ctl_filt, 3'b001);
        ctl_raw = 3'b000;
        tick(3);
        chk("R3 fall not yet", ctl_filt, 3'b001);
        tick();
        chk("R3 fall at latency 3", ctl_filt, 3'b000);
    endtask

    task automatic t_high_glitch(input int w);
        do_reset(2'b01);
        ctl_raw = 3'b001;
        tick(w);
        ctl_raw = 3'b000;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R4 high pulse removed", ctl_filt, 3'b000);
        end
    endtask

    task automatic t_three_pass();
        do_reset(2'b01);
        ctl_raw = 3'b100;
        tick(3);
        ctl_raw = 3'b000;
        tick();
        chk("R3 3-cycle pulse passes", ctl_filt, 3'b100);
        tick(2);
        chk("R3 3-cycle pulse width", ctl_filt, 3'b100);
        tick();
        chk("R3 3-cycle pulse ends", ctl_filt, 3'b000);
    endtask

    task automatic t_low_glitch(input int w);
        do_reset(2'b01);
        ctl_raw = 3'b111;
        tick(5);
        chk("R5 settled high", ctl_filt, 3'b111);
        ctl_raw = 3'b000;
        tick(w);
        ctl_raw = 3'b111;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R5 low glitch removed", ctl_filt, 3'b111);
        end
    endtask

    task automatic t_indep();
        do_reset(2'b01);
        ctl_raw = 3'b011;
        tick();
        ctl_raw = 3'b010;
        tick(3);
        chk("R6 hsync passes, enable glitch dropped", ctl_filt, 3'b010);
    endtask

    // Transitions on channel ch separated by g1 then g2 clocks (g2 == 0: two only).
    task automatic t_budget(input string tag, input logic [1:0] m, input int ch,
                            input int g1, input int g2, input logic [2:0] exp);
        do_reset(m);
        ctl_raw[ch] = 1'b1;
        tick(g1);
        ctl_raw[ch] = 1'b0;
        tick();
        if (g2 > 0) begin
            chk({tag, " two transitions within budget"}, budget_viol, 3'b000);
            tick(g2 - 1);
            ctl_raw[ch] = 1'b1;
            tick();
        end
        chk(tag, budget_viol, exp);
    endtask

    task automatic t_sticky();
        do_reset(2'b00);
        ctl_raw[2] = 1'b1;
        tick(20);
        ctl_raw[2] = 1'b0;
        tick();
        chk("R9 vsync short pulse flags", budget_viol, 3'b100);
        mode_code = 2'b01;
        tick(200);
        chk("R9 flag held", budget_viol, 3'b100);
        do_reset(2'b00);
        tick();
        chk("R9 reset clears flag", budget_viol, 3'b000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bypass(2'b00);
        t_bypass(2'b10);
        t_bypass(2'b11);
        t_latency();
        t_three_pass();
        t_high_glitch(1);
        t_high_glitch(2);
        t_low_glitch(1);
        t_low_glitch(2);
        t_indep();
        t_budget("R7 enable third toggle at 129 flags", 2'b00, 0, 60, 69, 3'b001);
        t_budget("R7 hsync third toggle at 129 flags in filter mode", 2'b01, 1, 60, 69, 3'b010);
        t_budget("R7 enable third toggle at 130 ok", 2'b00, 0, 60, 70, 3'b000);
        t_budget("R7 enable two close toggles ok", 2'b00, 0, 5, 0, 3'b000);
        t_budget("R8 vsync pulse 129 flags", 2'b00, 2, 129, 0, 3'b100);
        t_budget("R8 vsync pulse 130 ok", 2'b00, 2, 130, 0, 3'b000);
        t_sticky();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule